// File: doc/BRIEF.md
# Bad Packet Capture Analyzer

This block sits at the receive end of a link test. It takes a stream of 32-bit words, each marked as valid, start-of-packet or end-of-packet and carrying five error flags. Every word it accepts is written straight into a capture RAM. The write address is rewound at the start of each packet to the first free location. That location moves forward only when a packet that carried an error is kept, so a clean packet is overwritten by the one after it. In the end the capture RAM holds only damaged packets, stored back to back.

For each kept packet, a small table records where the packet starts and which error types it contained. The block counts clean packets and damaged packets. It also counts flagged words for each error type: CRC, loss of sync, K-character, not-in-table and recovered clock. A time counter runs while the link is under test. When the test is closed, the block writes the table, the counters and the time value to a status RAM, one word per cycle, and then raises `done`.

Top module: `bpa_capture`

## Requirements
- R1: After reset, `cap_we`, `stat_we` and `done` are 0. A `start` pulse, honoured only when idle or done, clears the capture address, the rewind address, the table, every counter and the time counter.
- R2: Each accepted word is written to the capture RAM on the next clock edge: `cap_we` is 1 for one cycle and `cap_data` equals the input word unchanged.
- R3: While waiting for a packet, only a valid word with `in_sop` set is accepted, and other valid words produce no capture write. Inside a packet, every valid word is accepted, including one with `in_sop` set, until a word with `in_eop` closes it. A word with both flags is a one-word packet.
- R4: The first word of a packet is written at the rewind address, which is 0 after `start`. Later words of the packet go to consecutive addresses, wrapping modulo 2^AW.
- R5: A packet is damaged when any of its words, from first to last, carries a nonzero error flag. When a damaged packet is kept, the rewind address moves to the word after its last word. A clean packet leaves the rewind address unchanged, so the next packet starts at the same place.
- R6: Table entry k holds the start address of the k-th kept packet and the OR of its error flags. The flag bits are bit0 CRC, bit1 loss of sync, bit2 K-character, bit3 not-in-table and bit4 recovered clock. Once DEPTH entries are kept, later damaged packets are counted but not stored and do not move the rewind address.
- R7: The clean and damaged packet counts rise by one as each packet closes. Each per-type error counter rises by one for every accepted word that has that flag set.
- R8: The time counter rises by one on every clock edge at which the block is waiting for a packet or inside one. This includes the edge that sees `end_test`.
- R9: `end_test`, while waiting or inside a packet, drops any partial packet, and a word presented in that cycle is ignored. The block then writes 2*DEPTH+9 status words at addresses 0 upward, one per cycle: pointers at 0..DEPTH-1, status at DEPTH..2*DEPTH-1, then clean count, damaged count, the CRC, loss-of-sync, K-character, not-in-table and recovered-clock counts, time, and the number of kept entries. After that, `done` stays 1 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run and clear all state |
| end_test | input | 1 | Close the run and begin the status dump |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Word is first of a packet |
| in_eop | input | 1 | Word is last of a packet |
| in_data | input | DW | Received data word |
| in_err | input | 5 | Per-word error flags (CRC, sync, K-char, not-in-table, recovered clock) |
| cap_we | output | 1 | Capture RAM write enable |
| cap_addr | output | AW | Capture RAM write address |
| cap_data | output | DW | Capture RAM write data |
| stat_we | output | 1 | Status RAM write enable |
| stat_addr | output | clog2(2*DEPTH+9) | Status RAM write address |
| stat_data | output | DW | Status RAM write data |
| done | output | 1 | Status dump complete |

## Verification
A capture write is due on the clock edge after the edge that accepts its word. The bench therefore drives each word at a falling edge and checks the capture port at the next falling edge, before it drives the following word. Table entries, counters and time are seen only through the dump. The dump begins in the cycle after the edge that takes `end_test` and lasts exactly 2*DEPTH+9 cycles, so the bench gathers the status port at each falling edge until `done` rises and counts the words it receives. The bench keeps its own time tally and adds one for every edge it drives while a run is active, including the `end_test` edge, so the time word is predicted without any look at the design's internals.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int NERR = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PKT,
    ST_DUMP,
    ST_DONE
  } st_e;

  // number of status words written at the end of a run
  function automatic int dump_len(input int depth);
    return 2 * depth + 9;
  endfunction
endpackage

// File: rtl/bpa_pkt_tracker.sv
module bpa_pkt_tracker #(
  parameter int AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     word_ok,
  input  logic                     first,
  input  logic                     last,
  input  logic                     tbl_full,
  input  logic [bpa_pkg::NERR-1:0] err,
  output logic [AW-1:0]            cur_addr,
  output logic [AW-1:0]            pkt_start,
  output logic [bpa_pkg::NERR-1:0] pkt_stat,
  output logic                     pkt_close,
  output logic                     pkt_bad,
  output logic                     pkt_store
);
  logic [AW-1:0]            wr_q, rew_q, start_q;
  logic [bpa_pkg::NERR-1:0] acc_q;

  assign cur_addr  = first ? rew_q : wr_q;
  assign pkt_start = first ? rew_q : start_q;
  assign pkt_stat  = first ? err : (acc_q | err);
  assign pkt_close = word_ok && last;
  assign pkt_bad   = |pkt_stat;
  assign pkt_store = pkt_close && pkt_bad && !tbl_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rew_q   <= '0;
      start_q <= '0;
      acc_q   <= '0;
    end else if (clear) begin
      wr_q    <= '0;
      rew_q   <= '0;
      start_q <= '0;
      acc_q   <= '0;
    end else if (word_ok) begin
      wr_q    <= cur_addr + AW'(1);
      start_q <= pkt_start;
      acc_q   <= pkt_stat;
      if (pkt_store) rew_q <= cur_addr + AW'(1);
    end
  end
endmodule

// File: rtl/bpa_bad_table.sv
module bpa_bad_table #(
  parameter  int AW    = 8,
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int IW    = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     store,
  input  logic [AW-1:0]            start_addr,
  input  logic [bpa_pkg::NERR-1:0] stat,
  input  logic [PW-1:0]            rd_sel,
  output logic [AW-1:0]            rd_ptr,
  output logic [bpa_pkg::NERR-1:0] rd_stat,
  output logic [IW-1:0]            count,
  output logic                     full
);
  logic [AW-1:0]            ptr_q  [DEPTH];
  logic [bpa_pkg::NERR-1:0] stat_q [DEPTH];

  assign full    = (count == IW'(DEPTH));
  assign rd_ptr  = ptr_q[rd_sel];
  assign rd_stat = stat_q[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        ptr_q[e]  <= '0;
        stat_q[e] <= '0;
      end
    end else if (clear) begin
      count <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        ptr_q[e]  <= '0;
        stat_q[e] <= '0;
      end
    end else if (store) begin
      ptr_q[count[PW-1:0]]  <= start_addr;
      stat_q[count[PW-1:0]] <= stat;
      count                 <= count + IW'(1);
    end
  end
endmodule

// File: rtl/bpa_err_counters.sv
module bpa_err_counters #(
  parameter int CW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              word_ok,
  input  logic                              pkt_close,
  input  logic                              pkt_bad,
  input  logic [bpa_pkg::NERR-1:0]          err,
  output logic [bpa_pkg::NERR-1:0][CW-1:0]  err_cnt,
  output logic [CW-1:0]                     good_cnt,
  output logic [CW-1:0]                     bad_cnt
);
  for (genvar k = 0; k < bpa_pkg::NERR; k++) begin : g_type
    logic [CW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q <= '0;
      else if (clear)              q <= '0;
      else if (word_ok && err[k])  q <= q + CW'(1);
    end
    assign err_cnt[k] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (clear) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (pkt_close) begin
      if (pkt_bad) bad_cnt  <= bad_cnt + CW'(1);
      else         good_cnt <= good_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/bpa_capture.sv
module bpa_capture #(
  parameter  int AW    = 8,
  parameter  int DEPTH = 16,
  parameter  int DW    = 32,
  parameter  int CW    = 16,
  localparam int DN    = bpa_pkg::dump_len(DEPTH),
  localparam int SAW   = $clog2(DN),
  localparam int PW    = $clog2(DEPTH),
  localparam int IW    = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     end_test,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [DW-1:0]            in_data,
  input  logic [bpa_pkg::NERR-1:0] in_err,
  output logic                     cap_we,
  output logic [AW-1:0]            cap_addr,
  output logic [DW-1:0]            cap_data,
  output logic                     stat_we,
  output logic [SAW-1:0]           stat_addr,
  output logic [DW-1:0]            stat_data,
  output logic                     done
);
  import bpa_pkg::*;

  st_e st_q, st_d;
  logic [SAW-1:0] idx_q;
  logic [DW-1:0]  time_q;

  // named internal events
  logic clear, active, first, word_ok;
  logic [AW-1:0]   cur_addr, pkt_start, rd_ptr;
  logic [NERR-1:0] pkt_stat, rd_stat;
  logic pkt_close, pkt_bad, pkt_store, tbl_full;
  logic [IW-1:0]   stored_n;
  logic [PW-1:0]   rd_sel;
  logic [NERR-1:0][CW-1:0] err_cnt;
  logic [CW-1:0]   good_cnt, bad_cnt;

  assign clear   = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign active  = (st_q == ST_WAIT) || (st_q == ST_PKT);
  assign first   = (st_q == ST_WAIT);
  assign word_ok = in_valid && !end_test &&
                   ((st_q == ST_WAIT && in_sop) || st_q == ST_PKT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_WAIT;
      ST_WAIT: begin
        if (end_test)                st_d = ST_DUMP;
        else if (word_ok && !in_eop) st_d = ST_PKT;
      end
      ST_PKT: begin
        if (end_test)               st_d = ST_DUMP;
        else if (word_ok && in_eop) st_d = ST_WAIT;
      end
      ST_DUMP: if (idx_q == SAW'(DN - 1)) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      time_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= (st_q == ST_DUMP) ? idx_q + SAW'(1) : '0;
      if (clear)       time_q <= '0;
      else if (active) time_q <= time_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_we   <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      cap_we <= word_ok;
      if (word_ok) begin
        cap_addr <= cur_addr;
        cap_data <= in_data;
      end
    end
  end

  bpa_pkt_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .word_ok(word_ok),
    .first(first), .last(in_eop), .tbl_full(tbl_full), .err(in_err),
    .cur_addr(cur_addr), .pkt_start(pkt_start), .pkt_stat(pkt_stat),
    .pkt_close(pkt_close), .pkt_bad(pkt_bad), .pkt_store(pkt_store)
  );

  bpa_bad_table #(.AW(AW), .DEPTH(DEPTH)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .store(pkt_store),
    .start_addr(pkt_start), .stat(pkt_stat), .rd_sel(rd_sel),
    .rd_ptr(rd_ptr), .rd_stat(rd_stat), .count(stored_n), .full(tbl_full)
  );

  bpa_err_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .word_ok(word_ok),
    .pkt_close(pkt_close), .pkt_bad(pkt_bad), .err(in_err),
    .err_cnt(err_cnt), .good_cnt(good_cnt), .bad_cnt(bad_cnt)
  );

  // status dump word select
  always_comb begin
    int unsigned iv;
    iv        = int'(idx_q);
    rd_sel    = PW'(iv < DEPTH ? iv : iv - DEPTH);
    stat_data = '0;
    if (iv < DEPTH)          stat_data = DW'(rd_ptr);
    else if (iv < 2 * DEPTH) stat_data = DW'(rd_stat);
    else begin
      unique case (iv - 2 * DEPTH)
        0:       stat_data = DW'(good_cnt);
        1:       stat_data = DW'(bad_cnt);
        2:       stat_data = DW'(err_cnt[0]);
        3:       stat_data = DW'(err_cnt[1]);
        4:       stat_data = DW'(err_cnt[2]);
        5:       stat_data = DW'(err_cnt[3]);
        6:       stat_data = DW'(err_cnt[4]);
        7:       stat_data = time_q;
        default: stat_data = DW'(stored_n);
      endcase
    end
  end

  assign stat_we   = (st_q == ST_DUMP);
  assign stat_addr = idx_q;
  assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/bpa_capture_chk.sv
module bpa_capture_chk #(
  parameter  int AW    = 8,
  parameter  int DEPTH = 16,
  parameter  int DW    = 32,
  parameter  int CW    = 16,
  localparam int IW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          active,
  input logic          word_ok,
  input logic [DW-1:0] in_data,
  input logic          cap_we,
  input logic [DW-1:0] cap_data,
  input logic          stat_we,
  input logic          done,
  input logic [IW-1:0] stored_n,
  input logic [DW-1:0] time_q,
  input logic [CW-1:0] good_cnt,
  input logic [CW-1:0] bad_cnt
);
  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (good_cnt == '0 && bad_cnt == '0 && stored_n == '0 && time_q == '0));

  // R2
  cap_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> $past(word_ok));

  // R2
  cap_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> cap_data == $past(in_data));

  // R6
  table_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stored_n <= IW'(DEPTH));

  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_n == IW'(DEPTH) && !clear) |=> stored_n == IW'(DEPTH));

  // R8
  time_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> time_q == $past(time_q) + DW'(1));

  // R9
  dump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (!done && !cap_we));
endmodule

bind bpa_capture bpa_capture_chk #(.AW(AW), .DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .active(active), .word_ok(word_ok),
  .in_data(in_data), .cap_we(cap_we), .cap_data(cap_data), .stat_we(stat_we),
  .done(done), .stored_n(stored_n), .time_q(time_q), .good_cnt(good_cnt),
  .bad_cnt(bad_cnt)
);

// File: tb/bpa_capture_tb.sv
`timescale 1ns/1ps
module bpa_capture_tb;
  localparam int AW = 6, DEPTH = 4, DW = 32, CW = 16;
  localparam int DN = 2 * DEPTH + 9;
  localparam int SAW = $clog2(DN);
  localparam int AMOD = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, end_test = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [4:0] in_err = '0;
  logic cap_we, stat_we, done;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data, stat_data;
  logic [SAW-1:0] stat_addr;

  always #2 clk = ~clk;

  bpa_capture #(.AW(AW), .DEPTH(DEPTH), .DW(DW), .CW(CW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  // reference state
  bit m_run = 0, m_inpkt = 0;
  int m_rew, m_wr, m_start, m_n, m_good, m_bad, m_time;
  int m_acc;
  int m_ptr[DEPTH], m_st[DEPTH], m_ec[5];
  logic [DW-1:0] dmp[DN];
  int word_seq = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_rew = 0; m_wr = 0; m_start = 0; m_n = 0; m_good = 0; m_bad = 0;
    m_time = 0; m_acc = 0; m_inpkt = 0;
    for (int i = 0; i < DEPTH; i++) begin m_ptr[i] = 0; m_st[i] = 0; end
    for (int i = 0; i < 5; i++) m_ec[i] = 0;
  endtask

  // drive one word at a falling edge, check the capture port one edge later
  task automatic send(input bit sop, input bit eop, input int err);
    bit acc;
    int addr;
    logic [DW-1:0] d;
    word_seq++;
    d = 32'hC0DE_0000 ^ DW'(word_seq * 131);
    acc = m_inpkt || sop;
    addr = 0;
    if (acc) begin
      if (!m_inpkt) begin addr = m_rew; m_start = addr; m_acc = err; end
      else begin addr = m_wr; m_acc = m_acc | err; end
      m_wr = (addr + 1) % AMOD;
      for (int k = 0; k < 5; k++) if (err[k]) m_ec[k]++;
      if (eop) begin
        if (m_acc != 0) begin
          m_bad++;
          if (m_n < DEPTH) begin
            m_ptr[m_n] = m_start; m_st[m_n] = m_acc; m_n++;
            m_rew = (addr + 1) % AMOD;
          end
        end else m_good++;
        m_inpkt = 0;
      end else m_inpkt = 1;
    end
    in_valid = 1'b1; in_sop = sop; in_eop = eop; in_err = 5'(err); in_data = d;
    @(posedge clk);
    if (m_run) m_time++;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = '0;
    chk(acc ? "R2 write" : "R3 ignored word", cap_we, acc);
    if (acc && cap_we) begin
      chk("R4 address", cap_addr, addr);
      chk("R2 data", cap_data, d);
    end
  endtask

  task automatic packet(input int len, input int err_pos, input int err);
    for (int i = 0; i < len; i++)
      send(i == 0, i == len - 1, (i == err_pos) ? err : 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (m_run) m_time++;
      @(negedge clk);
    end
  endtask

  task automatic run_start();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    model_clear();
    m_run = 1;
  endtask

  task automatic run_end();
    int got, guard;
    end_test = 1'b1;
    @(posedge clk);
    m_time++;
    @(negedge clk);
    end_test = 1'b0;
    m_run = 0; m_inpkt = 0;
    got = 0; guard = 0;
    for (int i = 0; i < DN; i++) dmp[i] = '1;
    while (!done && guard < 4 * DN) begin
      if (stat_we) begin dmp[stat_addr] = stat_data; got++; end
      guard++;
      @(negedge clk);
    end
    chk("R9 dump length", got, DN);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 pointer", dmp[i], (i < m_n) ? m_ptr[i] : 0);
      chk("R6 status", dmp[DEPTH + i], (i < m_n) ? m_st[i] : 0);
    end
    chk("R7 clean count", dmp[2*DEPTH], m_good);
    chk("R7 damaged count", dmp[2*DEPTH+1], m_bad);
    for (int k = 0; k < 5; k++) chk("R7 type count", dmp[2*DEPTH+2+k], m_ec[k]);
    chk("R8 time", dmp[2*DEPTH+7], m_time);
    chk("R6 kept entries", dmp[2*DEPTH+8], m_n);
    idle(3);
    chk("R9 done held", done, 1);
    chk("R9 no writes after dump", stat_we, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 reset cap_we", cap_we, 0);
    chk("R1 reset stat_we", stat_we, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 idle no write", cap_we, 0);

    // run 1: rewind, keep, wrap, table full
    run_start();
    send(1'b0, 1'b0, 0);            // R3 no sop while waiting
    send(1'b0, 1'b1, 3);
    packet(3, -1, 0);               // clean at 0
    idle(2);
    packet(2, -1, 0);               // R5 reuses 0
    packet(4, 2, 5'b00100);         // kept at 0
    send(1'b1, 1'b0, 0);            // R3 inner sop is data
    send(1'b1, 1'b0, 0);
    send(1'b0, 1'b1, 0);
    packet(1, 0, 5'b10001);         // one-word damaged
    packet(40, 39, 5'b00010);
    packet(30, 0, 5'b01000);        // R4 wraps
    packet(3, 1, 5'b00001);         // R6 counted, not kept
    packet(2, -1, 0);
    run_end();

    // run 2: sweep all flag patterns
    run_start();
    for (int p = 0; p < 32; p++) begin
      packet(2, 1, p);
      idle(p % 3);
    end
    run_end();

    // run 3: R1 clearing, empty run
    run_start();
    run_end();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule